// File: doc/BRIEF.md
# Low-Power Wake and Watchdog Controller

This block tracks the power state of a small processor core: running, idling (clocks alive, no execution) or sleeping. A sleep instruction strobe moves a running core into one of the two low-power states, chosen by a select input. Any enabled interrupt, or an expiry of the watchdog, brings the core back to running. Every return passes through a fixed settling window before the core may execute again. If the return was caused by an interrupt and the global interrupt enable was set at that moment, a one-cycle branch request is raised on the first executing cycle.

The watchdog is a base divider of tick pulses followed by a binary postscaler whose length is chosen at run time. When it expires while the core is idle or asleep, the core is woken. When it expires while the core is running, a one-cycle reset pulse is produced instead. Several events restart the watchdog: an explicit clear strobe, an accepted sleep instruction, a lost clock while clock monitoring is on, and a rewrite of the internal oscillator frequency while that oscillator drives the core.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While running and executing, a sleep strobe moves `pmode` on the next cycle to 2 (sleep) when `idle_sel` is 0 and to 1 (idle) when it is 1; `pmode` 0 means run. A sleep strobe during the settling window or in a low-power state has no effect.
- R2: In idle or sleep, any interrupt whose flag and enable bits are both 1 returns `pmode` to 0 on the next cycle with `exec_en` low; a flag whose enable bit is 0 causes no wake.
- R3: `vec_req` is a one-cycle pulse on the first cycle `exec_en` is high after a wake, raised only if an interrupt caused the wake and `gie` was 1 in the wake cycle; a watchdog-only wake raises none.
- R4: After a wake, `exec_en` stays low for SETTLE (default 8) cycles and rises on the next one.
- R5: A watchdog expiry in idle or sleep wakes the core and produces no `wdt_rst`.
- R6: A watchdog expiry in run mode raises `wdt_rst` for exactly one cycle, one cycle after the expiring tick, and leaves `pmode` at 0.
- R7: `wdt_count` is {postscaler, base}; the base counts ticks modulo BASE_DIV (default 4, 2 bits), each base wrap adds one to the postscaler, and the watchdog expires on the tick where base is BASE_DIV-1 and the postscaler equals 2^`wdt_ps_sel`-1, after which both read 0.
- R8: A `clrwdt` strobe or an accepted sleep strobe zeroes `wdt_count` on the next cycle, taking priority over a tick in the same cycle.
- R9: `clk_fail` zeroes the watchdog only while `clkmon_en` is 1; otherwise the count proceeds.
- R10: `freq_wr` zeroes the watchdog only while `intosc_sel` is 1; otherwise the count proceeds.
- R11: Synchronous reset gives `pmode` 0, `exec_en` 1, `wdt_count` 0 and no pulses, and wins over a wake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_flag | input | N_IRQ | Pending flag per interrupt source |
| irq_en | input | N_IRQ | Enable per interrupt source |
| gie | input | 1 | Global interrupt enable |
| sleep_req | input | 1 | Sleep instruction strobe |
| idle_sel | input | 1 | Low-power target: 0 sleep, 1 idle |
| clrwdt | input | 1 | Watchdog clear instruction strobe |
| wdt_tick | input | 1 | Watchdog time base tick |
| wdt_ps_sel | input | 4 | Postscaler length as a power of two |
| clk_fail | input | 1 | Selected clock reported lost |
| clkmon_en | input | 1 | Clock failure monitoring enabled |
| freq_wr | input | 1 | Internal oscillator frequency select written |
| intosc_sel | input | 1 | Internal oscillator is the core clock |
| pmode | output | 2 | Power mode: 0 run, 1 idle, 2 sleep |
| exec_en | output | 1 | Core may execute |
| vec_req | output | 1 | Branch-to-vector request pulse |
| wdt_rst | output | 1 | Watchdog reset pulse |
| wdt_count | output | 16+BASE_W | {postscaler, base} watchdog count |

## Verification
Wakes are driven by enabled interrupts with the global enable on and off, by masked interrupts that must not wake, and by watchdog expiry alone, which separates the vector decision from the wake decision. Watchdog expiry is provoked both in run mode and in idle, telling the reset path from the wake path. Each clear source is applied with its qualifier off and then on, and with a tick in the same cycle, so a gated clear is distinguishable from a plain count. A long stretch of random strobes, flags and resets is compared cycle by cycle with a behavioural model.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pmode_e;

    localparam int PS_W = 16;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            expire;
    } wdt_ps_t;

    // all-ones mask of sel bits: last postscaler value before expiry
    function automatic logic [PS_W-1:0] ps_limit(input logic [3:0] sel);
        logic [PS_W-1:0] lim;
        for (int i = 0; i < PS_W; i++) begin
            lim[i] = (i < int'(sel));
        end
        return lim;
    endfunction

    function automatic pmode_e low_mode(input logic idle_sel);
        return idle_sel ? PM_IDLE : PM_SLEEP;
    endfunction

endpackage

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
    parameter int N_IRQ = 4
) (
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             irq_any
);
    logic [N_IRQ-1:0] hit;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_src
        assign hit[g] = irq_flag[g] & irq_en[g];
    end

    assign irq_any = |hit;
endmodule

// File: rtl/wdt_clear_mux.sv
module wdt_clear_mux (
    input  logic sleep_ok,
    input  logic clrwdt,
    input  logic clk_fail,
    input  logic clkmon_en,
    input  logic freq_wr,
    input  logic intosc_sel,
    output logic wdt_clr
);
    logic clk_lost_clr;
    logic osc_wr_clr;

    always_comb begin
        clk_lost_clr = clk_fail & clkmon_en;
        osc_wr_clr   = freq_wr & intosc_sel;
        wdt_clr      = clrwdt | sleep_ok | clk_lost_clr | osc_wr_clr;
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import pmw_pkg::*;
#(
    parameter int BASE_DIV = 4,
    localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              clr,
    input  logic [3:0]        ps_sel,
    output logic [BASE_W-1:0] base,
    output logic [PS_W-1:0]   ps,
    output logic              expire
);
    localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(BASE_DIV - 1);

    logic    base_wrap;
    wdt_ps_t nxt;

    always_comb begin
        base_wrap  = tick && (base == BASE_LAST);
        nxt.expire = !clr && base_wrap && (ps == ps_limit(ps_sel));
        nxt.ps     = ps;
        if (clr || nxt.expire) begin
            nxt.ps = '0;
        end else if (base_wrap) begin
            nxt.ps = ps + 1'b1;
        end
        expire = nxt.expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            ps   <= '0;
        end else begin
            ps <= nxt.ps;
            if (clr || base_wrap) begin
                base <= '0;
            end else if (tick) begin
                base <= base + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pmw_pkg::*;
#(
    parameter int SETTLE = 8,
    localparam int SET_W = $clog2(SETTLE + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   irq_any,
    input  logic   gie,
    input  logic   sleep_req,
    input  logic   idle_sel,
    input  logic   wdt_expire,
    output pmode_e mode,
    output logic   exec_en,
    output logic   vec_req,
    output logic   wdt_rst,
    output logic   sleep_ok
);
    localparam logic [SET_W-1:0] SETTLE_LD = SET_W'(SETTLE);

    logic [SET_W-1:0] settle_cnt;
    logic             vec_pend;
    logic             wake;

    always_comb begin
        exec_en  = (mode == PM_RUN) && (settle_cnt == '0);
        sleep_ok = exec_en && sleep_req;
        vec_req  = exec_en && vec_pend;
        wake     = (mode != PM_RUN) && (irq_any || wdt_expire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= PM_RUN;
            settle_cnt <= '0;
            vec_pend   <= 1'b0;
            wdt_rst    <= 1'b0;
        end else begin
            wdt_rst <= wdt_expire && (mode == PM_RUN);
            if (mode == PM_RUN) begin
                if (settle_cnt != '0) begin
                    settle_cnt <= settle_cnt - 1'b1;
                end
                if (vec_req) begin
                    vec_pend <= 1'b0;
                end
                if (sleep_ok) begin
                    mode <= low_mode(idle_sel);
                end
            end else if (wake) begin
                mode       <= PM_RUN;
                settle_cnt <= SETTLE_LD;
                vec_pend   <= irq_any && gie;
            end
        end
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pmw_pkg::*;
#(
    parameter int N_IRQ    = 4,
    parameter int SETTLE   = 8,
    parameter int BASE_DIV = 4,
    localparam int BASE_W  = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1,
    localparam int CNT_W   = PS_W + BASE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             gie,
    input  logic             sleep_req,
    input  logic             idle_sel,
    input  logic             clrwdt,
    input  logic             wdt_tick,
    input  logic [3:0]       wdt_ps_sel,
    input  logic             clk_fail,
    input  logic             clkmon_en,
    input  logic             freq_wr,
    input  logic             intosc_sel,
    output logic [1:0]       pmode,
    output logic             exec_en,
    output logic             vec_req,
    output logic             wdt_rst,
    output logic [CNT_W-1:0] wdt_count
);
    logic              irq_any;
    logic              sleep_ok;
    logic              wdt_clr;
    logic              wdt_expire;
    logic [BASE_W-1:0] wdt_base;
    logic [PS_W-1:0]   wdt_ps;
    pmode_e            mode;

    irq_wake_det #(.N_IRQ(N_IRQ)) u_irq (
        .irq_flag (irq_flag),
        .irq_en   (irq_en),
        .irq_any  (irq_any)
    );

    wdt_clear_mux u_clr (
        .sleep_ok   (sleep_ok),
        .clrwdt     (clrwdt),
        .clk_fail   (clk_fail),
        .clkmon_en  (clkmon_en),
        .freq_wr    (freq_wr),
        .intosc_sel (intosc_sel),
        .wdt_clr    (wdt_clr)
    );

    wdt_timer #(.BASE_DIV(BASE_DIV)) u_wdt (
        .clk    (clk),
        .rst    (rst),
        .tick   (wdt_tick),
        .clr    (wdt_clr),
        .ps_sel (wdt_ps_sel),
        .base   (wdt_base),
        .ps     (wdt_ps),
        .expire (wdt_expire)
    );

    pm_fsm #(.SETTLE(SETTLE)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .irq_any    (irq_any),
        .gie        (gie),
        .sleep_req  (sleep_req),
        .idle_sel   (idle_sel),
        .wdt_expire (wdt_expire),
        .mode       (mode),
        .exec_en    (exec_en),
        .vec_req    (vec_req),
        .wdt_rst    (wdt_rst),
        .sleep_ok   (sleep_ok)
    );

    assign pmode     = mode;
    assign wdt_count = {wdt_ps, wdt_base};
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
    import pmw_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IRQ-1:0] irq_flag,
    input logic [N_IRQ-1:0] irq_en,
    input logic             sleep_req,
    input logic             idle_sel,
    input logic             clrwdt,
    input logic [1:0]       pmode,
    input logic             exec_en,
    input logic             vec_req,
    input logic             wdt_rst,
    input logic [CNT_W-1:0] wdt_count
);
    // R1
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode == PM_RUN && exec_en && sleep_req) |=>
        (pmode == ($past(idle_sel) ? 2'd1 : 2'd2)));

    // R2
    irq_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode != PM_RUN && |(irq_flag & irq_en)) |=> (pmode == PM_RUN && !exec_en));

    // R3
    vec_exec_chk: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> exec_en);

    // R3
    vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_req |=> !vec_req);

    // R4
    exec_run_chk: assert property (@(posedge clk) disable iff (rst)
        exec_en |-> (pmode == PM_RUN));

    // R5
    lowpwr_no_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode != PM_RUN) |=> !wdt_rst);

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R8
    clrwdt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clrwdt |=> (wdt_count == '0));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pmode == PM_RUN && exec_en && wdt_count == '0 && !wdt_rst && !vec_req));
endmodule

bind pwr_wake_ctrl pwr_wake_chk #(.N_IRQ(N_IRQ), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_flag  (irq_flag),
    .irq_en    (irq_en),
    .sleep_req (sleep_req),
    .idle_sel  (idle_sel),
    .clrwdt    (clrwdt),
    .pmode     (pmode),
    .exec_en   (exec_en),
    .vec_req   (vec_req),
    .wdt_rst   (wdt_rst),
    .wdt_count (wdt_count)
);

// File: tb/tb_pwr_wake_ctrl.sv
module tb_pwr_wake_ctrl;
    localparam int N_IRQ  = 4;
    localparam int SETTLE = 8;
    localparam int BDIV   = 4;
    localparam int CNT_W  = 18;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [N_IRQ-1:0] irq_flag = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             gie = 1'b0;
    logic             sleep_req = 1'b0;
    logic             idle_sel = 1'b0;
    logic             clrwdt = 1'b0;
    logic             wdt_tick = 1'b0;
    logic [3:0]       wdt_ps_sel = 4'd1;
    logic             clk_fail = 1'b0;
    logic             clkmon_en = 1'b0;
    logic             freq_wr = 1'b0;
    logic             intosc_sel = 1'b0;
    logic [1:0]       pmode;
    logic             exec_en;
    logic             vec_req;
    logic             wdt_rst;
    logic [CNT_W-1:0] wdt_count;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // behavioural reference state
    int m_mode = 0, m_cnt = 0, m_base = 0, m_ps = 0;
    bit m_vp = 0, m_rst = 0, m_valid = 0;

    always #2 clk = ~clk;

    pwr_wake_ctrl #(.N_IRQ(N_IRQ), .SETTLE(SETTLE), .BASE_DIV(BDIV)) dut (
        .clk(clk), .rst(rst), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
        .sleep_req(sleep_req), .idle_sel(idle_sel), .clrwdt(clrwdt),
        .wdt_tick(wdt_tick), .wdt_ps_sel(wdt_ps_sel), .clk_fail(clk_fail),
        .clkmon_en(clkmon_en), .freq_wr(freq_wr), .intosc_sel(intosc_sel),
        .pmode(pmode), .exec_en(exec_en), .vec_req(vec_req), .wdt_rst(wdt_rst),
        .wdt_count(wdt_count)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model, updated at each active edge from the driven inputs
    always @(posedge clk) begin
        bit clr, expire, irq, sleep_acc, exec, vq;
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            wrap_up();
        end
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_base = 0; m_ps = 0; m_vp = 0; m_rst = 0;
        end else begin
            exec      = (m_mode == 0) && (m_cnt == 0);
            vq        = exec && m_vp;
            sleep_acc = exec && sleep_req;
            clr       = clrwdt || sleep_acc || (clk_fail && clkmon_en) || (freq_wr && intosc_sel);
            expire    = !clr && wdt_tick && (m_base == BDIV - 1) &&
                        (m_ps == (1 << wdt_ps_sel) - 1);
            irq       = |(irq_flag & irq_en);
            m_rst     = expire && (m_mode == 0);
            if (clr || expire) begin
                m_base = 0; m_ps = 0;
            end else if (wdt_tick) begin
                if (m_base == BDIV - 1) begin
                    m_base = 0; m_ps = (m_ps + 1) % 65536;
                end else begin
                    m_base++;
                end
            end
            if (m_mode == 0) begin
                if (m_cnt > 0) m_cnt--;
                if (vq) m_vp = 0;
                if (sleep_acc) m_mode = idle_sel ? 1 : 2;
            end else if (irq || expire) begin
                m_mode = 0; m_cnt = SETTLE; m_vp = irq && gie;
            end
        end
        m_valid = 1;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done) begin
            bit mexec;
            mexec = (m_mode == 0) && (m_cnt == 0);
            chk("R1 pmode vs model", pmode, m_mode);
            chk("R4 exec_en vs model", exec_en, mexec);
            chk("R3 vec_req vs model", vec_req, mexec && m_vp);
            chk("R6 wdt_rst vs model", wdt_rst, m_rst);
            chk("R7 wdt_count vs model", wdt_count, (m_ps << 2) | m_base);
        end
    end

    initial begin
        step(2);
        // R11 reset state
        chk("R11 reset pmode", pmode, 0);
        chk("R11 reset exec_en", exec_en, 1);
        chk("R11 reset count", wdt_count, 0);
        rst = 0;

        // R7 counting, R8 clear beats tick
        wdt_tick = 1;
        step(3); chk("R7 base count", wdt_count, 3);
        step(1); chk("R7 postscaler step", wdt_count, 4);
        clrwdt = 1; step(1); chk("R8 clear beats tick", wdt_count, 0);
        clrwdt = 0;

        // R6 expiry in run mode
        step(7); chk("R6 no reset early", wdt_rst, 0); chk("R7 last count", wdt_count, 7);
        step(1); chk("R6 reset pulse", wdt_rst, 1); chk("R7 wrap to zero", wdt_count, 0);
        step(1); chk("R6 pulse ends", wdt_rst, 0); chk("R6 still run", pmode, 0);
        wdt_tick = 0;

        // R9 clock-fail clear gated by monitor enable
        clrwdt = 1; step(1); clrwdt = 0;
        wdt_tick = 1;
        step(2); chk("R9 pre count", wdt_count, 2);
        clk_fail = 1; step(1); chk("R9 no monitor no clear", wdt_count, 3);
        clkmon_en = 1; step(1); chk("R9 monitor clears", wdt_count, 0);
        clk_fail = 0; clkmon_en = 0;

        // R10 frequency write clear gated by oscillator source
        step(2); chk("R10 pre count", wdt_count, 2);
        freq_wr = 1; step(1); chk("R10 ext osc no clear", wdt_count, 3);
        intosc_sel = 1; step(1); chk("R10 int osc clears", wdt_count, 0);
        freq_wr = 0; intosc_sel = 0; wdt_tick = 0;

        // R1 sleep entry, R2 masked/enabled irq, R3 vector, R4 settle
        idle_sel = 0; sleep_req = 1; step(1); sleep_req = 0;
        chk("R1 enter sleep", pmode, 2);
        chk("R8 sleep clears wdt", wdt_count, 0);
        irq_flag = 4'b0010; irq_en = 4'b0001;
        step(3); chk("R2 masked irq no wake", pmode, 2);
        gie = 1; irq_en = 4'b0010;
        step(1); chk("R2 wake to run", pmode, 0); chk("R4 exec low at wake", exec_en, 0);
        irq_flag = '0; irq_en = '0; gie = 0;
        step(7); chk("R4 exec still low", exec_en, 0);
        step(1); chk("R4 exec rises", exec_en, 1); chk("R3 vector on irq wake", vec_req, 1);
        step(1); chk("R3 vector one cycle", vec_req, 0);

        // R5 watchdog wake from idle, no vector
        idle_sel = 1; sleep_req = 1; step(1); sleep_req = 0;
        chk("R1 enter idle", pmode, 1);
        gie = 1; wdt_ps_sel = 0; wdt_tick = 1;
        step(3); chk("R5 idle before expiry", pmode, 1);
        step(1); chk("R5 wdt wake", pmode, 0); chk("R5 no reset", wdt_rst, 0);
        wdt_tick = 0; sleep_req = 1;
        step(1); sleep_req = 0;
        chk("R1 sleep ignored while settling", pmode, 0); chk("R5 no reset after", wdt_rst, 0);
        step(7); chk("R4 exec after wdt wake", exec_en, 1); chk("R3 no vector on wdt wake", vec_req, 0);
        gie = 0; wdt_ps_sel = 1;

        // R11 reset beats wake
        idle_sel = 0; sleep_req = 1; step(1); sleep_req = 0;
        irq_flag = 4'b0001; irq_en = 4'b0001; rst = 1;
        step(1); chk("R11 reset over wake mode", pmode, 0); chk("R11 no settle", exec_en, 1);
        rst = 0; irq_flag = '0; irq_en = '0;
        step(1);

        // random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            sleep_req  = ($urandom % 12) == 0;
            idle_sel   = $urandom % 2;
            clrwdt     = ($urandom % 40) == 0;
            wdt_tick   = $urandom % 2;
            clk_fail   = ($urandom % 50) == 0;
            clkmon_en  = $urandom % 2;
            freq_wr    = ($urandom % 50) == 0;
            intosc_sel = $urandom % 2;
            irq_flag   = (($urandom % 6) == 0) ? N_IRQ'($urandom) : '0;
            irq_en     = N_IRQ'($urandom);
            gie        = $urandom % 2;
            rst        = ($urandom % 700) == 0;
            if (($urandom % 200) == 0) wdt_ps_sel = 4'($urandom % 3);
            step(1);
        end
        rst = 0;
        step(2);
        wrap_up();
    end
endmodule